// File: doc/BRIEF.md
# FIFO-Buffered PWM Generator

A single-channel pulse-width modulator controlled through a small word-addressed register port. Software queues duty values in a four-word sample queue. The period counter takes one queued value at the end of each PWM period, or at the end of every 2nd, 4th or 8th period when sample repeat is selected. The counter is clocked through a programmable divider. Each period is the programmed period value plus two divided ticks long. The output can be normal, inverted or held low.

The block is used by writing the period register and one or more sample words, then setting the enable bit together with a non-zero clock source. Raw event flags in the status register let software see counter rollover, compare hits, an empty queue and dropped writes. These flags are cleared by writing 1 to them. A self-clearing soft reset bit returns everything to its power-up state and empties the queue.

Top module: `pwm_fifo_gen`

## Requirements
- R1: Registers are selected by `bus_addr`: 0 control, 1 status, 2 sample, 3 period. After reset, control, sample and period read 0, status reads 0x08 (queue empty) and `pwm_out` is low. Writes take effect at the clock edge where `bus_wr` is high. Reads are combinational.
- R2: With enable (control bit 0) set and clock source (control bits 17:16) non-zero, the output period is (P+2)*(D+1) clock cycles. P is the period register and D is control bits 15:4, a divide-minus-one value from 0 to 4095.
- R3: A period register value of 0xFFFF produces the same period as 0xFFFE, which is 65536 divided ticks. The register still reads back 0xFFFF.
- R4: Control bits 19:18 = 0 give normal polarity. The output is high for S divided ticks from the start of each period, where S is the active sample, and low for the rest of the period. When S is at least P+2, the output stays high.
- R5: Control bits 19:18 = 1 invert the output. A value of 2 (or 3) holds `pwm_out` low while the counter keeps running.
- R6: Control bits 2:1 = 0, 1, 2 or 3 make each sample last 1, 2, 4 or 8 periods before the next queued sample is taken.
- R7: The sample queue holds 4 words, in first-in first-out order. Status bits 2:0 give the number of queued words and status bit 3 is set while the queue is empty. While the counter is stopped and no sample has been taken since reset, the first queued word moves into the active sample on the next cycle.
- R8: A sample write while 4 words are queued is dropped and sets status bit 6. Writing 1 to status bit 6 clears it.
- R9: Status bit 4 (rollover) is set when a period ends, and status bit 5 (compare) is set on a divided tick in which the counter equals the active sample. Both stay set until 1 is written to them.
- R10: Writing control with bit 3 set starts a soft reset. For one cycle bit 3 reads 1 and the other control fields are unchanged. After that, all registers, flags and the queue are back to their reset values.
- R11: With enable clear or clock source 0, the counter holds at its start, no flags are raised and, under normal polarity, `pwm_out` is low.
- R12: A new sample is taken only at the end of a period, so a write during a period does not change that period's duty cycle. When the queue is empty at the end of a period, the active sample is reused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| pwm_out | output | 1 | PWM output |

## Verification
Several properties are checked on every cycle: the queue occupancy never exceeds four, a write to a full queue always raises the write error flag, the held-low output select keeps the output low, and a stopped counter stays at its start with the output low. They also check that soft reset clears control and the queue one cycle after it is requested, and that the active sample never changes inside a running period. The bench scenarios are the only check on the measured period and high time across divider settings and random period and sample pairs. They also cover the 0xFFFF period case, the order in which samples leave the queue, the repeat counts, the reuse of the last sample and the clearing of the flags.

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen #(
  parameter int SW = 16,
  parameter int PW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        pwm_out
);
  localparam int DEPTH = 4;
  localparam logic [PW-1:0] PMAX = {PW{1'b1}};

  logic [19:0]   ctrl;
  logic          srst_q;
  logic [PW-1:0] per_r, cnt, plim, last;
  logic [11:0]   pre_cnt;
  logic [2:0]    rep_cnt, rep_last, fcnt;
  logic [SW-1:0] cur;
  logic [SW-1:0] mem [DEPTH];
  logic [1:0]    rp, wp, outsel;
  logic          loaded, err_f, cmp_f, rov_f;
  logic          running, tick, wrap, rep_done, raw;
  logic          wr_ctl, wr_st, wr_smp, push, pop, pop_stop, pop_run;
  logic          unused_bits;

  assign outsel   = ctrl[19:18];
  assign running  = ctrl[0] && (ctrl[17:16] != 2'd0) && !srst_q;
  assign plim     = (per_r == PMAX) ? PMAX - 1'b1 : per_r;
  assign last     = plim + 1'b1;
  assign tick     = running && (pre_cnt == ctrl[15:4]);
  assign wrap     = tick && (cnt >= last);
  assign rep_last = 3'((1 << ctrl[2:1]) - 1);
  assign rep_done = (rep_cnt == rep_last);

  assign wr_ctl   = bus_wr && bus_addr == 2'd0 && !srst_q;
  assign wr_st    = bus_wr && bus_addr == 2'd1 && !srst_q;
  assign wr_smp   = bus_wr && bus_addr == 2'd2 && !srst_q;
  assign push     = wr_smp && fcnt != 3'd4;
  assign pop_stop = !running && !loaded && fcnt != 3'd0 && !srst_q;
  assign pop_run  = wrap && rep_done && fcnt != 3'd0;
  assign pop      = pop_stop || pop_run;

  assign raw      = running && (32'(cnt) < 32'(cur));
  assign pwm_out  = outsel[1] ? 1'b0 : (raw ^ outsel[0]);
  assign unused_bits = ^bus_wdata[31:20];

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {12'd0, ctrl[19:4], srst_q, ctrl[2:0]};
      2'd1:    bus_rdata = {25'd0, err_f, cmp_f, rov_f, fcnt == 3'd0, fcnt};
      2'd2:    bus_rdata = 32'(cur);
      default: bus_rdata = 32'(per_r);
    endcase
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= bus_wdata[SW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || srst_q) begin
      ctrl <= '0; srst_q <= 1'b0; per_r <= '0; cnt <= '0; pre_cnt <= '0;
      rep_cnt <= '0; cur <= '0; rp <= '0; wp <= '0; fcnt <= '0;
      loaded <= 1'b0; err_f <= 1'b0; cmp_f <= 1'b0; rov_f <= 1'b0;
    end else begin
      if (wr_ctl) begin
        if (bus_wdata[3]) srst_q <= 1'b1;
        else              ctrl   <= bus_wdata[19:0] & ~20'h8;
      end
      if (bus_wr && bus_addr == 2'd3) per_r <= bus_wdata[PW-1:0];
      if (push) wp <= wp + 1'b1;
      if (pop) begin
        rp  <= rp + 1'b1;
        cur <= mem[rp];
      end
      if (pop_stop) loaded <= 1'b1;
      fcnt <= fcnt + {2'b0, push} - {2'b0, pop};

      if (!running) begin
        pre_cnt <= '0; cnt <= '0; rep_cnt <= '0;
      end else if (tick) begin
        pre_cnt <= '0;
        if (wrap) begin
          cnt     <= '0;
          rep_cnt <= rep_done ? 3'd0 : rep_cnt + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end

      err_f <= (err_f && !(wr_st && bus_wdata[6])) || (wr_smp && fcnt == 3'd4);
      cmp_f <= (cmp_f && !(wr_st && bus_wdata[5])) || (tick && 32'(cnt) == 32'(cur));
      rov_f <= (rov_f && !(wr_st && bus_wdata[4])) || wrap;
    end
  end
endmodule

// File: rtl/pwm_fifo_gen_chk.sv
module pwm_fifo_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        srst_q,
  input logic        running,
  input logic        wrap,
  input logic        pwm_out,
  input logic        bus_wr,
  input logic        err_f,
  input logic [1:0]  bus_addr,
  input logic [1:0]  outsel,
  input logic [2:0]  fcnt,
  input logic [15:0] cnt,
  input logic [15:0] cur,
  input logic [19:0] ctrl
);
  p_occ_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= 3'd4);

  p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && fcnt == 3'd4 && !srst_q) |=> err_f);

  p_forced_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    outsel[1] |-> !pwm_out);

  p_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> cnt == 16'd0);

  p_stopped_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && outsel == 2'd0) |-> !pwm_out);

  p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (ctrl == 20'd0 && fcnt == 3'd0 && !srst_q));

  p_duty_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !wrap && !srst_q) |=> $stable(cur));
endmodule

bind pwm_fifo_gen pwm_fifo_gen_chk i_chk (
  .clk(clk), .rst_n(rst_n), .srst_q(srst_q), .running(running), .wrap(wrap),
  .pwm_out(pwm_out), .bus_wr(bus_wr), .err_f(err_f), .bus_addr(bus_addr),
  .outsel(outsel), .fcnt(fcnt), .cnt(cnt), .cur(cur), .ctrl(ctrl)
);

// File: tb/test_pwm_fifo_gen.sv
`timescale 1ns/1ps
module test_pwm_fifo_gen;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic pwm_out;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  pwm_fifo_gen i_pwm_fifo_gen (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  function automatic int exp_per(int p, int d);
    int pl = (p >= 65535) ? 65534 : p;
    return (pl + 2) * d;
  endfunction

  function automatic int exp_hi(int s, int p, int d);
    int pl = (p >= 65535) ? 65534 : p;
    return ((s > pl + 1) ? pl + 2 : s) * d;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bwrite(int a, int d);
    bus_addr = a[1:0]; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(int a, output int d);
    bus_addr = a[1:0];
    #1 d = int'(bus_rdata);
  endtask

  task automatic soft_reset();
    bwrite(0, 8);
    @(negedge clk);
  endtask

  task automatic measure(input bit inv, output int per, output int hi);
    logic p, v;
    per = 0; hi = 0;
    do begin
      v = pwm_out ^ inv; hi += int'(v); per++; p = v;
      @(negedge clk);
    end while (!(p == 1'b0 && (pwm_out ^ inv) == 1'b1));
  endtask

  task automatic hold(input logic lvl, input int n, output int bad);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out !== lvl) bad++;
      @(negedge clk);
    end
  endtask

  task automatic run_case(string tag, int p, int s, int d, int cs);
    int per, hi;
    soft_reset();
    bwrite(2, s); bwrite(3, p);
    bwrite(0, ((d - 1) << 4) | (cs << 16) | 1);
    measure(1'b0, per, hi);
    chk({tag, " R2 period"}, per, exp_per(p, d));
    chk({tag, " R4 high time"}, hi, exp_hi(s, p, d));
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int v, per, hi, bad;
    int wv[6] = '{3, 7, 11, 5, 9, 15};
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bread(0, v); chk("R1 ctrl", v, 0);
    bread(1, v); chk("R1 status", v, 8);
    bread(2, v); chk("R1 sample", v, 0);
    bread(3, v); chk("R1 period", v, 0);
    chk("R1 out", int'(pwm_out), 0);

    // R10 soft reset
    bwrite(2, 9); bwrite(2, 9); bwrite(3, 30); bwrite(0, 32'h10001);
    repeat (7) @(negedge clk);
    bwrite(0, 8);
    bread(0, v); chk("R10 ctrl during reset", v, 32'h10009);
    @(negedge clk);
    bread(0, v); chk("R10 ctrl after", v, 0);
    bread(1, v); chk("R10 status after", v, 8);
    bread(2, v); chk("R10 sample after", v, 0);
    bread(3, v); chk("R10 period after", v, 0);
    chk("R10 out after", int'(pwm_out), 0);

    // R7 R8 queue fill, overflow, order, reuse
    for (int i = 0; i < 6; i++) bwrite(2, wv[i]);
    bread(1, v); chk("R8 status full+error", v, 32'h44);
    bread(2, v); chk("R7 first word preloaded", v, wv[0]);
    bwrite(1, 32'h40);
    bread(1, v); chk("R8 error cleared", v, 4);
    bwrite(3, 20); bwrite(0, 32'h10001);
    for (int i = 0; i < 6; i++) begin
      measure(1'b0, per, hi);
      chk("R7 period", per, exp_per(20, 1));
      chk("R12 queue order/reuse", hi, exp_hi(wv[(i > 4) ? 4 : i], 20, 1));
    end
    bread(1, v); chk("R9 flags set, queue empty", v, 32'h38);
    bwrite(0, 0); bwrite(1, 32'h30);
    bread(1, v); chk("R9 flags cleared", v, 8);

    // R12 write mid-period
    soft_reset();
    bwrite(2, 6); bwrite(3, 20); bwrite(0, 32'h10001);
    measure(1'b0, per, hi); chk("R12 first period", hi, 6);
    bwrite(2, 15);
    measure(1'b0, per, hi);
    chk("R12 rest of period", per, 21); chk("R12 duty unchanged", hi, 5);
    measure(1'b0, per, hi); chk("R12 new sample", hi, 15);
    measure(1'b0, per, hi); chk("R12 reuse", hi, 15);

    // R6 repeat counts
    for (int r = 1; r < 4; r++) begin
      soft_reset();
      bwrite(2, 4); bwrite(2, 10); bwrite(3, 16);
      bwrite(0, 32'h10001 | (r << 1));
      for (int k = 0; k <= (1 << r); k++) begin
        measure(1'b0, per, hi);
        chk("R6 repeat", hi, (k < (1 << r)) ? 4 : 10);
      end
    end

    // R2 R4 random and directed
    for (int i = 0; i < 8; i++) begin
      int p = 2 + int'($urandom % 30);
      int d = 1 + int'($urandom % 4);
      int s = 1 + int'($urandom % (p + 1));
      int cs = 1 + int'($urandom % 3);
      run_case("rand", p, s, d, cs);
    end
    run_case("P=0", 0, 1, 1, 1);
    run_case("S=P+1", 5, 6, 3, 2);
    run_case("max divider", 1, 1, 4096, 3);

    // R4 always high
    soft_reset();
    bwrite(2, 8); bwrite(3, 6); bwrite(0, 32'h10001);
    hold(1'b1, 40, bad); chk("R4 always high", bad, 0);

    // R3 0xFFFF period
    soft_reset();
    bwrite(2, 100); bwrite(3, 32'hFFFF);
    bread(3, v); chk("R3 readback", v, 32'hFFFF);
    bwrite(0, 32'h10001);
    measure(1'b0, per, hi);
    chk("R3 period", per, exp_per(65535, 1)); chk("R3 high", hi, 100);

    // R5 inverted and forced low
    soft_reset();
    bwrite(2, 5); bwrite(3, 10); bwrite(0, 32'h50001);
    measure(1'b1, per, hi);
    chk("R5 inverted period", per, 12); chk("R5 inverted low time", hi, 5);
    soft_reset();
    bwrite(2, 5); bwrite(3, 10); bwrite(0, 32'h90001);
    hold(1'b0, 40, bad); chk("R5 forced low", bad, 0);
    bread(1, v); chk("R5 counter still runs", v & 32'h10, 32'h10);

    // R11 stopped counter
    soft_reset();
    bwrite(2, 5); bwrite(3, 4); bwrite(0, 1);
    hold(1'b0, 30, bad); chk("R11 source off low", bad, 0);
    bread(1, v); chk("R11 source off no flags", v, 8);
    bwrite(0, 32'h10000);
    hold(1'b0, 30, bad); chk("R11 disabled low", bad, 0);
    bread(1, v); chk("R11 disabled no flags", v, 8);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule